// File: doc/BRIEF.md
# Delay-and-Multiply AFSK Demodulator with Bit-Phase Tracking

This block turns a stream of signed 8-bit audio samples into recovered data bits. The samples arrive at eight per bit period. Each incoming sample is multiplied by the sample taken half a bit period earlier. The sign of that product depends on the tone frequency, so the multiplier works as a frequency discriminator. A low-pass filter built only from adders and arithmetic shifts smooths the product. Each filter output is then reduced to one bit by checking whether it is positive, and that bit is pushed into a short history register.

A phase accumulator decides when each bit is sampled. It advances by a fixed step on every sample. When the history shows a transition, the accumulator is nudged by one count towards the centre of its range, and over time this aligns the sampling instant with the middle of each bit. When the accumulator wraps, the block takes a majority vote over the three newest history bits. It then emits a data bit: 1 when the vote agrees with the previous vote, and 0 when it differs. The output is therefore already NRZI-decoded. The block has no framing, no flag detection and no converter interface; a downstream parser consumes the bit stream.

Top module: `afsk_demod`

## Requirements
- R1: The synchronous active-low reset clears the delay line, the filter state, the slice history, the phase accumulator and the previous vote. While reset is held, `bit_vld` and `bit_data` are 0.
- R2: Each sample is multiplied by the sample taken SPB/2 accepted samples earlier. After reset, the first SPB/2 samples are multiplied by zero.
- R3: The filter input is the signed product shifted arithmetically right by 2.
- R4: The filter computes y = x_prev + x_cur + (y>>>1) + (y>>>3) + (y>>>5), where x_prev is the previous filter input. The 16-bit state saturates instead of wrapping.
- R5: Each sample pushes a history bit into the slice history. The bit is 1 exactly when the new filter output is greater than zero.
- R6: When the two newest history bits differ, the phase first moves by 1: up when it is below SPB*4, down otherwise.
- R7: After any nudge, the phase advances by 8 per sample. When it reaches SPB*8, it wraps modulo SPB*8 and a bit is produced for that sample. With a zero input after reset, a bit is produced on every 8th sample.
- R8: The vote at a bit instant is 1 when at least two of the three newest history bits (including the one from the current sample) are 1.
- R9: `bit_data` is 1 when the new vote equals the previous vote, and 0 otherwise. The previous vote is 0 after reset.
- R10: Clock cycles with `sample_vld` low change no state and never raise `bit_vld`.
- R11: `bit_vld` is a single-cycle pulse that is registered on the same clock edge that accepts the sample which produced it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | Sample strobe; one audio sample is accepted per high cycle |
| sample_data | input | 8 | Signed two's-complement audio sample |
| bit_vld | output | 1 | Pulses for one cycle when a decoded bit is available |
| bit_data | output | 1 | Decoded bit, valid while `bit_vld` is high |

## Verification
Every result is due on the very clock edge that accepts its sample. The discriminator, filter, slicer and phase update are all combinational in front of one register stage, so `bit_vld` and `bit_data` change on that edge and at no other time. The bench drives each sample at a falling edge and compares the outputs at the next falling edge, which is half a cycle after the accepting edge. It compares against an arithmetic model that is stepped once per sample. Idle cycles inserted between samples are checked for a silent `bit_vld`. A directed zero-input run confirms that bits arrive every eighth sample with value 1.

// File: rtl/afsk_demod_pkg.sv
// Package: shared helpers for the AFSK demodulator.
// Assumes a three-bit history window for voting.
package afsk_demod_pkg;

    // Majority of three history bits.
    function automatic logic maj3(input logic [2:0] h);
        return (h[0] & h[1]) | (h[0] & h[2]) | (h[1] & h[2]);
    endfunction

    // Transition between the two newest history bits.
    function automatic logic newest_edge(input logic [2:0] h);
        return h[0] ^ h[1];
    endfunction

endpackage

// File: rtl/afsk_delay_line.sv
// Module: shift-register delay line of DEPTH signed samples.
// Shifts only when en is high. Reset fills it with zeros.
// dout is the sample accepted DEPTH enables earlier.
module afsk_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] tap [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        if (g == 0) begin : g_head
            // Load the newest sample into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n)  tap[g] <= '0;
                else if (en) tap[g] <= din;
            end
        end else begin : g_body
            // Move each stored sample one stage along.
            always_ff @(posedge clk) begin
                if (!rst_n)  tap[g] <= '0;
                else if (en) tap[g] <= tap[g-1];
            end
        end
    end

    assign dout = tap[DEPTH-1];
endmodule

// File: rtl/afsk_discrim.sv
// Module: product discriminator plus shift-only IIR low-pass.
// The new filter output and its sign slice are combinational from
// the current inputs and the stored state. The state registers
// update only when en is high. Widths are sized so no sum wraps,
// and the stored output saturates to Y_W bits.
module afsk_discrim #(
    parameter int SAMPLE_W = 8,
    parameter int Y_W      = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] cur,
    input  logic signed [SAMPLE_W-1:0] dly,
    output logic                       slice
);
    localparam int PROD_W = 2 * SAMPLE_W;
    localparam int SUM_W  = ((Y_W > PROD_W) ? Y_W : PROD_W) + 3;
    localparam logic signed [SUM_W-1:0] Y_HI = SUM_W'((64'sd1 <<< (Y_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] Y_LO = -SUM_W'(64'sd1 <<< (Y_W - 1));

    logic signed [PROD_W-1:0] prod, x_cur, x_prev;
    logic signed [Y_W-1:0]    y_q, y_next;
    logic signed [Y_W-1:0]    y_s1, y_s3, y_s5;
    logic signed [SUM_W-1:0]  sum;

    // Discriminator product and its quarter scaling.
    always_comb begin
        prod  = dly * cur;
        x_cur = prod >>> 2;
    end

    // Feedback taps: arithmetic right shifts of the stored output.
    always_comb begin
        y_s1 = y_q >>> 1;
        y_s3 = y_q >>> 3;
        y_s5 = y_q >>> 5;
    end

    // Sum the five terms in a wide accumulator with sign extension.
    always_comb begin
        sum = {{(SUM_W-PROD_W){x_prev[PROD_W-1]}}, x_prev}
            + {{(SUM_W-PROD_W){x_cur[PROD_W-1]}},  x_cur}
            + {{(SUM_W-Y_W){y_s1[Y_W-1]}}, y_s1}
            + {{(SUM_W-Y_W){y_s3[Y_W-1]}}, y_s3}
            + {{(SUM_W-Y_W){y_s5[Y_W-1]}}, y_s5};
    end

    // Clamp the sum into the stored output width.
    always_comb begin
        if (sum > Y_HI)      y_next = Y_HI[Y_W-1:0];
        else if (sum < Y_LO) y_next = Y_LO[Y_W-1:0];
        else                 y_next = sum[Y_W-1:0];
    end

    // Positive-output slicer.
    assign slice = (y_next > 0);

    // Hold the previous filter input and output between samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev <= '0;
            y_q    <= '0;
        end else if (en) begin
            x_prev <= x_cur;
            y_q    <= y_next;
        end
    end
endmodule

// File: rtl/afsk_bit_pll.sv
// Module: slice history, bit-phase accumulator, majority vote and
// NRZI decision. All state updates on en. bit_vld and bit_data are
// registered on the same edge as the sample that produced them.
module afsk_bit_pll
    import afsk_demod_pkg::*;
#(
    parameter int SPB  = 8,
    parameter int STEP = 8,
    parameter int PH_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            slice,
    output logic            bit_vld,
    output logic            bit_data,
    output logic [PH_W-1:0] phase
);
    localparam int PH_MAX  = SPB * STEP;
    localparam int PH_HALF = PH_MAX / 2;
    localparam logic [PH_W-1:0] MAX_V  = PH_W'(PH_MAX);
    localparam logic [PH_W-1:0] HALF_V = PH_W'(PH_HALF);
    localparam logic [PH_W-1:0] STEP_V = PH_W'(STEP);

    logic [2:0]      hist_q, hist_n;
    logic [PH_W-1:0] ph_q, ph_nudge, ph_adv, ph_n;
    logic            fire, vote, vote_q;

    // History including the slice of the sample now being accepted.
    assign hist_n = {hist_q[1:0], slice};

    // Nudge towards the centre on a transition, then advance and wrap.
    always_comb begin
        ph_nudge = ph_q;
        if (newest_edge(hist_n)) begin
            if (ph_q < HALF_V) ph_nudge = ph_q + 1'b1;
            else               ph_nudge = ph_q - 1'b1;
        end
        ph_adv = ph_nudge + STEP_V;
        fire   = (ph_adv >= MAX_V);
        ph_n   = fire ? (ph_adv - MAX_V) : ph_adv;
        vote   = maj3(hist_n);
    end

    // Register the history, the phase, the vote and the output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q   <= '0;
            ph_q     <= '0;
            vote_q   <= 1'b0;
            bit_vld  <= 1'b0;
            bit_data <= 1'b0;
        end else begin
            bit_vld <= en & fire;
            if (en) begin
                hist_q <= hist_n;
                ph_q   <= ph_n;
                if (fire) begin
                    vote_q   <= vote;
                    bit_data <= (vote == vote_q);
                end
            end
        end
    end

    assign phase = ph_q;
endmodule

// File: rtl/afsk_demod.sv
// Module: top of the AFSK demodulator. Delays each sample by half a
// bit, discriminates and filters it, then recovers NRZI-decoded bits.
// Assumes SPB is even and STEP is at least 2.
module afsk_demod #(
    parameter int SAMPLE_W = 8,
    parameter int SPB      = 8,
    parameter int STEP     = 8,
    parameter int Y_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_vld,
    input  logic [SAMPLE_W-1:0] sample_data,
    output logic                bit_vld,
    output logic                bit_data
);
    localparam int DEPTH = SPB / 2;
    localparam int PH_W  = $clog2(SPB * STEP + STEP + 2);

    logic signed [SAMPLE_W-1:0] cur_s, dly_s;
    logic                       slice;
    logic [PH_W-1:0]            bit_phase;

    assign cur_s = sample_data;

    afsk_delay_line #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_dly (
        .clk(clk), .rst_n(rst_n), .en(sample_vld), .din(cur_s), .dout(dly_s)
    );

    afsk_discrim #(.SAMPLE_W(SAMPLE_W), .Y_W(Y_W)) u_disc (
        .clk(clk), .rst_n(rst_n), .en(sample_vld),
        .cur(cur_s), .dly(dly_s), .slice(slice)
    );

    afsk_bit_pll #(.SPB(SPB), .STEP(STEP), .PH_W(PH_W)) u_pll (
        .clk(clk), .rst_n(rst_n), .en(sample_vld), .slice(slice),
        .bit_vld(bit_vld), .bit_data(bit_data), .phase(bit_phase)
    );
endmodule

// File: rtl/afsk_demod_chk.sv
// Checker: temporal properties of the demodulator, bound to the top.
module afsk_demod_chk #(
    parameter int SPB  = 8,
    parameter int STEP = 8,
    parameter int PH_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sample_vld,
    input logic            bit_vld,
    input logic [PH_W-1:0] phase
);
    localparam int PH_MAX  = SPB * STEP;
    localparam int MAX_GAP = (PH_MAX + STEP - 2) / (STEP - 1);
    localparam int CW      = $clog2(MAX_GAP + 2) + 1;

    logic          vld_d;
    logic [CW-1:0] gap_cnt;

    // Count accepted samples since the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_d   <= 1'b0;
            gap_cnt <= '0;
        end else begin
            vld_d <= sample_vld;
            if (vld_d) gap_cnt <= bit_vld ? '0 : gap_cnt + 1'b1;
        end
    end

    a_r7_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PH_W'(PH_MAX));

    a_r7_bit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= CW'(MAX_GAP - 1));

    a_r10_idle_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(phase));

    a_r10_idle_no_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> !bit_vld);

    a_r11_bit_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(sample_vld));
endmodule

bind afsk_demod afsk_demod_chk #(.SPB(SPB), .STEP(STEP), .PH_W(PH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
    .bit_vld(bit_vld), .phase(bit_phase)
);

// File: tb/sim_afsk_demod.sv
// Bench: drives sample patterns and compares every output against an
// arithmetic model stepped once per accepted sample.
module sim_afsk_demod;
    localparam int SPB = 8;
    localparam int DEPTH = SPB / 2;
    localparam int PH_MAX = SPB * 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_vld = 1'b0;
    logic [7:0] sample_data = '0;
    logic       bit_vld, bit_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_dl [DEPTH];
    int m_x, m_y, m_hist, m_ph, m_vote;

    always #5 clk = ~clk;

    afsk_demod u0 (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .sample_data(sample_data), .bit_vld(bit_vld), .bit_data(bit_data)
    );

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_dl[i] = 0;
        m_x = 0; m_y = 0; m_hist = 0; m_ph = 0; m_vote = 0;
    endtask

    // Model from R2..R9: returns whether a bit is due and its value.
    task automatic model_step(input int s, output bit ev, output bit eb);
        int xn, yn, sl, h3, vote, ones;
        xn = (m_dl[DEPTH-1] * s) >>> 2;
        yn = m_x + xn + (m_y >>> 1) + (m_y >>> 3) + (m_y >>> 5);
        if (yn > 32767) yn = 32767;
        if (yn < -32768) yn = -32768;
        m_x = xn; m_y = yn;
        sl = (yn > 0) ? 1 : 0;
        m_hist = ((m_hist << 1) | sl) & 7;
        for (int i = DEPTH - 1; i > 0; i--) m_dl[i] = m_dl[i-1];
        m_dl[0] = s;
        if (((m_hist ^ (m_hist >> 1)) & 1) != 0)
            m_ph = (m_ph < PH_MAX / 2) ? m_ph + 1 : m_ph - 1;
        m_ph = m_ph + 8;
        ev = 1'b0; eb = 1'b0;
        if (m_ph >= PH_MAX) begin
            m_ph = m_ph - PH_MAX;
            h3 = m_hist;
            ones = (h3 & 1) + ((h3 >> 1) & 1) + ((h3 >> 2) & 1);
            vote = (ones >= 2) ? 1 : 0;
            ev = 1'b1;
            eb = (vote == m_vote);
            m_vote = vote;
        end
    endtask

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // One sample, then `gaps` idle cycles each checked for silence (R10).
    task automatic send(input int s, input int gaps, input string tag);
        bit ev, eb;
        @(negedge clk);
        sample_vld = 1'b1;
        sample_data = 8'(s);
        model_step(s, ev, eb);
        @(negedge clk);
        sample_vld = 1'b0;
        check(tag, bit_vld, ev, "bit_vld");
        if (ev) check(tag, bit_data, eb, "bit_data");
        for (int g = 0; g < gaps; g++) begin
            @(negedge clk);
            check("R10", bit_vld, 1'b0, "idle bit_vld");
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sample_vld = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", bit_vld, 1'b0, "reset bit_vld");
        check("R1", bit_data, 1'b0, "reset bit_data");
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        int tone, cnt;
        real ph;
        model_reset();
        do_reset();

        // R7 R9: zero input gives a 1 on every 8th sample.
        cnt = 0;
        for (int n = 1; n <= 32; n++) begin
            @(negedge clk);
            sample_vld = 1'b1; sample_data = 8'd0;
            @(negedge clk);
            sample_vld = 1'b0;
            check("R7", bit_vld, (n % 8) == 0, "zero-input bit_vld");
            if ((n % 8) == 0) check("R9", bit_data, 1'b1, "zero-input bit_data");
        end
        model_reset();
        do_reset();

        // R2 R3 R5: constant positive level, delay line starts at zero.
        for (int n = 0; n < 40; n++) send(40, 0, "R2");
        // R3 R6: period-8 square wave gives negative products.
        for (int n = 0; n < 80; n++) send(((n / 4) % 2) ? -90 : 90, 0, "R3");
        // R4: full-scale extremes stress the filter range.
        for (int n = 0; n < 60; n++) send(-128, 0, "R4");
        for (int n = 0; n < 60; n++) send(((n / 4) % 2) ? 127 : -128, 0, "R4");

        // R6 R8 R9: NRZI-keyed two-tone signal, continuous phase.
        do_reset();
        tone = 0; ph = 0.0;
        for (int b = 0; b < 80; b++) begin
            if ($urandom_range(0, 1) == 0) tone = 1 - tone;
            for (int k = 0; k < SPB; k++) begin
                ph = ph + 2.0 * 3.14159265 * (tone ? 2200.0 : 1200.0) / 9600.0;
                send($rtoi(100.0 * $sin(ph)), 0, "R8");
            end
        end

        // R10 R11: random samples with random idle gaps.
        for (int n = 0; n < 400; n++)
            send($signed(8'($urandom)), $urandom_range(0, 3), "R11");

        // R1: reset mid-stream, then zero input behaves as after power-up.
        do_reset();
        for (int n = 1; n <= 16; n++) send(0, 0, "R1");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule